// File: doc/BRIEF.md
# Flash Sector Erase Command Sequencer

This block is the command-interface state machine that a NOR-style flash array uses to start a sector erase. It watches host write cycles (address, data and an active-low write strobe) and treats a rising edge of the strobe as one accepted write. A fixed series of unlock and set-up writes arms the machine. The last write of that series names a sector through the upper address bits, and that sector is placed in a one-hot selection mask.

Once the sequence is complete, an acceptance window opens. Further sector-erase writes made during the window add sectors to the mask and restart the window. Any other command discards the whole sequence. When the window runs out, the erase engine starts. It is modelled as a zeroing (pre-program and verify) phase followed by an erase phase, each lasting a fixed number of cycles. An erase-suspend command freezes the window or the engine, and a resume command continues from the frozen point. A hardware reset aborts everything.

Top module: `flash_erase_seq`

## Requirements
- R1: An active-low `rst_n` clears the mask and all status outputs at once, and it aborts any sequence, window or erase that is in progress.
- R2: A write is accepted on the first rising clock edge at which `we_n` is high after having been low at the previous edge. The six writes addr 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55 and then any address with data 0x30 (address bits [10:0] are compared) open the window. The mask is then set to the one-hot value of address bits [13:11].
- R3: A write that does not match the expected step of the unlock or set-up series returns the machine to idle. This leaves the mask zero and the outputs low.
- R4: During the window, each write with data 0x30 ORs the one-hot value of its sector into the mask. Sectors may be given in any order.
- R5: The window stays open for WIN_CYC cycles after its opening write or after the latest accepted 0x30 write.
- R6: A write during the window whose data is neither 0x30 nor 0xB0 closes the window, clears the mask and returns the machine to idle.
- R7: When the window expires, `timer_done` goes high. `zeroing` is then high for PREP_CYC cycles, followed by `erasing` for ERASE_CYC cycles.
- R8: When the erase phase ends, the machine returns to idle with the mask cleared and all status outputs low.
- R9: While zeroing or erasing, every write except 0xB0 is ignored, and the mask and the phase timing are unchanged.
- R10: Data 0xB0, at any address, written during the window, zeroing or erasing, raises `suspended` and freezes the phase counter. A later 0x30 write resumes the frozen phase, and all other writes during suspension are ignored. A suspend made during the window resumes into a full zeroing phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| we_n | input | 1 | Active-low write strobe; a write takes effect on its rising edge |
| addr | input | 14 | Write address; bits [13:11] select the sector |
| wdata | input | 8 | Write data (command code) |
| sect_mask | output | 8 | One-hot-per-sector erase selection |
| win_open | output | 1 | Acceptance window is open |
| timer_done | output | 1 | Window has expired (high while zeroing, erasing or suspended) |
| zeroing | output | 1 | Engine in the pre-program/verify phase |
| erasing | output | 1 | Engine in the erase phase |
| suspended | output | 1 | Erase activity is suspended |

## Verification
If the unlock progress is wrong, the fault shows on the sixth write: `win_open` and the mask either fail to appear or appear after a broken series. A wrong window or phase counter moves the edges of `timer_done`, `zeroing` or `erasing` by at least one cycle. The cycle-by-cycle reference comparison catches such a shift in the cycle where it occurs. A mask that is not cleared or that is corrupted shows directly on `sect_mask` in the cycle after the offending write or phase end.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int CMD_AW    = 11,
  parameter int SECT_W    = 3,
  parameter int WIN_CYC   = 50,
  parameter int PREP_CYC  = 20,
  parameter int ERASE_CYC = 40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_n,
  input  logic [CMD_AW+SECT_W-1:0]   addr,
  input  logic [7:0]                 wdata,
  output logic [(1<<SECT_W)-1:0]     sect_mask,
  output logic                       win_open,
  output logic                       timer_done,
  output logic                       zeroing,
  output logic                       erasing,
  output logic                       suspended
);
  localparam int NS    = 1 << SECT_W;
  localparam int AW    = CMD_AW + SECT_W;
  localparam int MAXC  = (WIN_CYC > PREP_CYC) ? ((WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC)
                                               : ((PREP_CYC > ERASE_CYC) ? PREP_CYC : ERASE_CYC);
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CMD_AW-1:0] KEY_A = CMD_AW'(12'h555);
  localparam logic [CMD_AW-1:0] KEY_B = CMD_AW'(12'h2AA);

  typedef enum logic [3:0] {
    IDLE, UNL1, UNL2, ARMD, UNL4, UNL5, WIND, PREP, ERAS, SUSP
  } st_t;

  st_t            st;
  logic           we_q;
  logic           back_erase;
  logic [CW-1:0]  cnt;

  wire            wr    = we_n & ~we_q;
  wire [CMD_AW-1:0] lo  = addr[CMD_AW-1:0];
  wire [NS-1:0]   pick  = NS'(1) << addr[AW-1:CMD_AW];
  wire            is_aa = wr && lo == KEY_A && wdata == 8'hAA;
  wire            is_55 = wr && lo == KEY_B && wdata == 8'h55;
  wire            is_80 = wr && lo == KEY_A && wdata == 8'h80;
  wire            is_30 = wr && wdata == 8'h30;
  wire            is_b0 = wr && wdata == 8'hB0;

  assign win_open   = (st == WIND);
  assign zeroing    = (st == PREP);
  assign erasing    = (st == ERAS);
  assign suspended  = (st == SUSP);
  assign timer_done = zeroing | erasing | suspended;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      we_q       <= 1'b1;
      back_erase <= 1'b0;
      cnt        <= '0;
      sect_mask  <= '0;
    end else begin
      we_q <= we_n;
      case (st)
        IDLE: if (is_aa) st <= UNL1;
        UNL1: if (wr) st <= is_55 ? UNL2 : IDLE;
        UNL2: if (wr) st <= is_80 ? ARMD : IDLE;
        ARMD: if (wr) st <= is_aa ? UNL4 : IDLE;
        UNL4: if (wr) st <= is_55 ? UNL5 : IDLE;
        UNL5: if (wr) begin
          if (is_30) begin
            st        <= WIND;
            sect_mask <= pick;
            cnt       <= CW'(WIN_CYC);
          end else st <= IDLE;
        end
        WIND: begin
          if (is_30) begin
            sect_mask <= sect_mask | pick;
            cnt       <= CW'(WIN_CYC);
          end else if (is_b0) begin
            st         <= SUSP;
            back_erase <= 1'b0;
            cnt        <= CW'(PREP_CYC);
          end else if (wr) begin
            st        <= IDLE;
            sect_mask <= '0;
            cnt       <= '0;
          end else if (cnt == CW'(1)) begin
            st  <= PREP;
            cnt <= CW'(PREP_CYC);
          end else cnt <= cnt - 1'b1;
        end
        PREP: begin
          if (is_b0) begin
            st         <= SUSP;
            back_erase <= 1'b0;
          end else if (cnt == CW'(1)) begin
            st  <= ERAS;
            cnt <= CW'(ERASE_CYC);
          end else cnt <= cnt - 1'b1;
        end
        ERAS: begin
          if (is_b0) begin
            st         <= SUSP;
            back_erase <= 1'b1;
          end else if (cnt == CW'(1)) begin
            st        <= IDLE;
            sect_mask <= '0;
            cnt       <= '0;
          end else cnt <= cnt - 1'b1;
        end
        SUSP: if (is_30) st <= back_erase ? ERAS : PREP;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int NS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NS-1:0] sect_mask,
  input logic          win_open,
  input logic          timer_done,
  input logic          zeroing,
  input logic          erasing,
  input logic          suspended
);
  // R2
  win_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> sect_mask != '0);

  // R6
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_open) |-> (timer_done || sect_mask == '0));

  // R7
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_open, zeroing, erasing, suspended}));

  // R7
  erase_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erasing) |-> ($past(zeroing) || $past(suspended)));

  // R8
  erase_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(erasing) && !suspended) |-> (sect_mask == '0 && !timer_done));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && $past(erasing)) |-> sect_mask == $past(sect_mask));
endmodule

bind flash_erase_seq flash_erase_seq_chk #(.NS(NS)) u_chk (.*);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int CLK_NS = 10;
  localparam int WIN = 50, PRE = 20, ERA = 40;

  logic clk = 0, rst_n = 0, we_n = 1;
  logic [13:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  sect_mask;
  logic win_open, timer_done, zeroing, erasing, suspended;

  int checks = 0, fails = 0;

  flash_erase_seq #(.WIN_CYC(WIN), .PREP_CYC(PRE), .ERASE_CYC(ERA)) u_dut (
    .clk, .rst_n, .we_n, .addr, .wdata, .sect_mask, .win_open,
    .timer_done, .zeroing, .erasing, .suspended);

  always #(CLK_NS/2) clk = ~clk;

  // reference: mode 0 idle, 1..5 steps of the key series matched,
  // 6 window, 7 zeroing, 8 erasing, 9 suspended
  int   m_mode = 0, m_left = 0, m_ret = 7, m_prev = 1;
  logic [7:0] m_mask = 0;
  int   key_a [5] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA};
  int   key_d [5] = '{'hAA, 'h55, 'h80, 'hAA, 'h55};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_mask = 0; m_prev = 1;
    end else begin
      bit w;
      int lo, sec;
      w = (we_n == 1 && m_prev == 0);
      m_prev = we_n;
      lo = addr[10:0];
      sec = addr[13:11];
      if (m_mode <= 5) begin
        if (w) begin
          if (m_mode == 5) begin
            if (wdata == 8'h30) begin m_mode = 6; m_mask = 8'(1 << sec); m_left = WIN; end
            else m_mode = 0;
          end else if (lo == key_a[m_mode] && wdata == key_d[m_mode]) m_mode++;
          else m_mode = 0;
        end
      end else if (m_mode == 9) begin
        if (w && wdata == 8'h30) m_mode = m_ret;
      end else if (w && wdata == 8'hB0) begin
        m_ret = (m_mode == 8) ? 8 : 7;
        if (m_mode == 6) m_left = PRE;
        m_mode = 9;
      end else if (m_mode == 6 && w) begin
        if (wdata == 8'h30) begin m_mask |= 8'(1 << sec); m_left = WIN; end
        else begin m_mode = 0; m_mask = 0; end
      end else begin
        m_left--;
        if (m_left == 0) begin
          if (m_mode == 6) begin m_mode = 7; m_left = PRE; end
          else if (m_mode == 7) begin m_mode = 8; m_left = ERA; end
          else begin m_mode = 0; m_mask = 0; end
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(sect_mask == m_mask, "R4 model mask", sect_mask, m_mask);
    chk(win_open == (m_mode == 6), "R5 model window", win_open, m_mode == 6);
    chk(zeroing == (m_mode == 7), "R7 model zeroing", zeroing, m_mode == 7);
    chk(erasing == (m_mode == 8), "R7 model erasing", erasing, m_mode == 8);
    chk(suspended == (m_mode == 9), "R10 model suspend", suspended, m_mode == 9);
    chk(timer_done == (m_mode >= 7), "R7 model timer", timer_done, m_mode >= 7);
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1; addr = 14'(a); wdata = 8'(d); we_n = 0;
    @(negedge clk); #1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic seq(int s);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr(s << 11, 'h30);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    chk(sect_mask == 0 && !timer_done && !win_open, "R1 reset state", sect_mask, 0);
    #1 rst_n = 1;
    idle(2);

    seq(3);
    chk(win_open == 1, "R2 window open", win_open, 1);
    chk(sect_mask == 8'h08, "R2 mask", sect_mask, 8'h08);
    idle(30);
    wr(5 << 11, 'h30);
    chk(sect_mask == 8'h28, "R4 add sector", sect_mask, 8'h28);
    wr(0, 'h30);
    chk(sect_mask == 8'h29, "R4 add sector 0", sect_mask, 8'h29);
    idle(45);
    chk(win_open == 1, "R5 window restarted", win_open, 1);
    idle(10);
    chk(zeroing == 1 && timer_done == 1, "R7 zeroing after window", zeroing, 1);
    wr('h555, 'hAA);
    chk(zeroing == 1 && sect_mask == 8'h29, "R9 ignored in zeroing", sect_mask, 8'h29);
    idle(20);
    chk(erasing == 1, "R7 erase phase", erasing, 1);
    wr('h555, 'hF0);
    chk(erasing == 1 && sect_mask == 8'h29, "R9 ignored in erase", sect_mask, 8'h29);
    idle(40);
    chk(!timer_done && sect_mask == 0, "R8 back to idle", sect_mask, 0);

    wr('h555, 'hAA); wr('h2AA, 'h00);
    chk(sect_mask == 0 && !win_open, "R3 broken series", win_open, 0);
    wr('h2AA, 'h55); wr('h555, 'h80); wr('h555, 'hAA); wr('h2AA, 'h55); wr(2 << 11, 'h30);
    chk(!win_open && sect_mask == 0, "R3 no resume after break", win_open, 0);

    seq(1);
    chk(sect_mask == 8'h02, "R2 second run", sect_mask, 8'h02);
    wr('h555, 'hF0);
    chk(!win_open && sect_mask == 0, "R6 foreign cmd", sect_mask, 0);

    seq(0);
    wr('h123, 'hB0);
    chk(suspended && timer_done && sect_mask == 8'h01, "R10 suspend in window", suspended, 1);
    idle(100);
    wr('h555, 'hAA);
    chk(suspended == 1, "R10 held suspended", suspended, 1);
    wr(0, 'h30);
    chk(zeroing == 1, "R10 resume zeroing", zeroing, 1);
    idle(25);
    wr(0, 'hB0);
    chk(suspended == 1, "R10 suspend in erase", suspended, 1);
    idle(50);
    wr(0, 'h30);
    chk(erasing == 1, "R10 resume erase", erasing, 1);
    idle(60);
    chk(!timer_done && sect_mask == 0, "R8 done after resume", sect_mask, 0);

    seq(7);
    idle(WIN + 5);
    chk(zeroing == 1, "R7 started", zeroing, 1);
    #1 rst_n = 0;
    #1 chk(sect_mask == 0 && !timer_done, "R1 reset aborts", sect_mask, 0);
    idle(2);
    #1 rst_n = 1;
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule